// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller Pair

This block joins two eight-input interrupt controllers into one sixteen-line interrupt router. One controller acts as the master and the other as the slave. Software reaches both controllers over a small byte-wide I/O bus. The bus has a command address and a data address per controller, plus one edge/level register per controller. Interrupt sources present a line number with a raise or lower strobe. The block routes lines 0 to 7 to the master and lines 8 to 15 to the slave. Any slave activity is also folded into the master's cascade input, which is request bit 2.

Toward the CPU there is one registered interrupt output and one eight-bit vector. An acknowledge strobe accepts the vector that is on offer. It moves the winning request into service and clears that request if its line is edge-triggered. Each controller learns its vector base through an initialisation sequence of byte writes. After that, it accepts mask writes, end-of-interrupt commands and a read-select command.

Top module: `pic_pair_top`

## Requirements
- R1: After reset, `cpu_intr` is 0, `intr_vector` is 0, both mask registers and both edge/level registers read 0, and a command-address read returns the request register, which is 0.
- R2: The decoded byte addresses are as follows. The master uses 0x020 for commands and 0x021 for data. The slave uses 0x0A0 for commands and 0x0A1 for data. The edge/level registers are at 0x4D0 (master) and 0x4D1 (slave). A write to any other address changes nothing, and a read from any other address returns 0xFF.
- R3: A raise strobe on line n sets a request bit. For n from 0 to 7, it sets master request bit n. For n from 8 to 15, it sets slave request bit n-8 and also master request bit 2. A lower strobe clears only the addressed bit. Line numbers 16 and above have no effect.
- R4: A write to 0x4D0 stores the data ANDed with 0xF8. A write to 0x4D1 stores the data ANDed with 0xDE. Reads return the stored value. A set bit marks its line as level-triggered.
- R5: A command write with bit 4 set starts initialisation, and the next data write becomes the vector base. After that, one more data write is consumed if the initialisation byte had bit 1 clear. Another data write is consumed if it had bit 0 set. Every other data write loads the mask register.
- R6: Once a controller is initialised, a command write with bits 4:3 = 01 selects what the command address reads back. Bits 1:0 = 10 select the request register, 11 selects the in-service register, and any other value reads back 0.
- R7: `cpu_intr` rises one cycle after an unmasked request exists in either controller. It is 0 in the cycle after any write to one of the four controller addresses.
- R8: The order of priority is master lines 0 and 1 first, then slave lines 8 to 15 (lowest first), then master lines 2 to 7. The vector is the owning controller's base plus its bit index. Masked requests are skipped. The vector is 0 when nothing is pending.
- R9: `intr_ack` sets the in-service bit of the winning request. It clears the request bit only when the line is edge-triggered. A slave acknowledge also sets master in-service bit 2 and clears master request bit 2.
- R10: These rules apply once a controller is initialised. A command write whose bits 7:5 are 011 clears the in-service bit given by bits 2:0. Bits 7:5 of 001 clear the lowest set in-service bit. Any other command with bits 4:3 = 00 leaves the in-service register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| req_raise | input | 1 | Raise the line in `req_line` |
| req_lower | input | 1 | Lower the line in `req_line` (raise wins if both) |
| req_line | input | 5 | Interrupt line number |
| intr_ack | input | 1 | CPU accepts the offered vector |
| cpu_intr | output | 1 | Registered interrupt request to the CPU |
| intr_vector | output | 8 | Vector of the highest-priority unmasked request |

## Verification
The embedded assertions watch three things on every cycle. They check that the CPU output is withdrawn after a controller write and restored while requests stay pending. They check that every slave raise shows up at master bit 2. They check that an acknowledge marks service and clears edge requests. The bench's scenarios cover the rest: the address decoding and unmapped reads, the exact masking of the edge/level registers over all byte values, and the initialisation paths. They also cover the pairwise priority order across all sixteen lines and the end-of-interrupt command variants, because those depend on sequences of bus traffic rather than on one cycle.

// File: rtl/pic_pair_pkg.sv
// Shared definitions for the cascaded controller pair.
// Assumes eight request inputs per controller and byte-wide registers.
package pic_pair_pkg;

    localparam int UNIT_W = 8;
    localparam int IDX_W  = $clog2(UNIT_W);

    // Initialisation progress of one controller.
    typedef enum logic [2:0] {
        INIT_IDLE,   // never initialised, data writes load the mask
        INIT_BASE,   // waiting for the vector base byte
        INIT_CASC,   // waiting for the cascade wiring byte
        INIT_MODE,   // waiting for the mode byte
        INIT_RUN     // operational
    } init_st_e;

    // Index of the lowest set bit, 0 when none is set.
    function automatic logic [IDX_W-1:0] lowest_idx(input logic [UNIT_W-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = UNIT_W - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/pic_level_reg.sv
// Edge/level control register of one controller.
// Only bits set in WMASK can ever hold a 1; the others stay edge-triggered.
module pic_level_reg
    import pic_pair_pkg::*;
#(
    parameter logic [UNIT_W-1:0] WMASK = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [UNIT_W-1:0] wdata,
    output logic [UNIT_W-1:0] q
);

    // Masked write storage, all lines edge-triggered after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            q <= wdata & WMASK;
        end
    end

endmodule

// File: rtl/pic_unit.sv
// One eight-input interrupt controller: initialisation sequencing, request,
// in-service and mask registers, end-of-interrupt commands and read select.
// Assumes the caller gates ack_vld so that ack_idx names a pending request.
module pic_unit
    import pic_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              data_wr,
    input  logic [UNIT_W-1:0] wdata,
    input  logic [UNIT_W-1:0] raise_vec,
    input  logic [UNIT_W-1:0] lower_vec,
    input  logic              ack_vld,
    input  logic [IDX_W-1:0]  ack_idx,
    input  logic [UNIT_W-1:0] level_mask,
    output logic [UNIT_W-1:0] irr,
    output logic [UNIT_W-1:0] isr,
    output logic [UNIT_W-1:0] imr,
    output logic [UNIT_W-1:0] vec_base,
    output logic [UNIT_W-1:0] cmd_rdata
);

    init_st_e          st;
    logic              single_mode;
    logic              need_mode;
    logic [1:0]        rd_sel;

    logic              is_init;
    logic              is_ocw2;
    logic              is_ocw3;
    logic              spec_eoi;
    logic              gen_eoi;
    logic [UNIT_W-1:0] eoi_clr;
    logic [UNIT_W-1:0] ack_onehot;
    logic [UNIT_W-1:0] ack_clr;

    // Command byte classification.
    always_comb begin
        is_init  = wdata[4];
        is_ocw2  = (wdata[4:3] == 2'b00);
        is_ocw3  = (wdata[4:3] == 2'b01);
        spec_eoi = cmd_wr && (st == INIT_RUN) && is_ocw2 && (wdata[7:5] == 3'b011);
        gen_eoi  = cmd_wr && (st == INIT_RUN) && is_ocw2 && (wdata[7:5] == 3'b001);
    end

    // In-service bits released by an end-of-interrupt command.
    always_comb begin
        if (spec_eoi)     eoi_clr = UNIT_W'(1) << wdata[IDX_W-1:0];
        else if (gen_eoi) eoi_clr = isr & (~isr + UNIT_W'(1));
        else              eoi_clr = '0;
    end

    // Request and in-service bits touched by an acknowledge.
    always_comb begin
        ack_onehot = ack_vld ? (UNIT_W'(1) << ack_idx) : '0;
        ack_clr    = ack_onehot & ~level_mask;
    end

    // Initialisation sequence, mask, vector base and read select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= INIT_IDLE;
            single_mode <= 1'b0;
            need_mode   <= 1'b0;
            vec_base    <= '0;
            imr         <= '0;
            rd_sel      <= 2'b10;
        end else if (cmd_wr && is_init) begin
            st          <= INIT_BASE;
            single_mode <= wdata[1];
            need_mode   <= wdata[0];
        end else if (cmd_wr && (st == INIT_RUN) && is_ocw3) begin
            rd_sel <= wdata[1:0];
        end else if (data_wr) begin
            case (st)
                INIT_BASE: begin
                    vec_base <= wdata;
                    if (!single_mode)   st <= INIT_CASC;
                    else if (need_mode) st <= INIT_MODE;
                    else                st <= INIT_RUN;
                end
                INIT_CASC: st <= need_mode ? INIT_MODE : INIT_RUN;
                INIT_MODE: st <= INIT_RUN;
                default:   imr <= wdata;
            endcase
        end
    end

    // Request and in-service register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr <= '0;
            isr <= '0;
        end else begin
            irr <= (irr & ~lower_vec & ~ack_clr) | raise_vec;
            isr <= (isr & ~eoi_clr) | ack_onehot;
        end
    end

    // Command address read-back.
    always_comb begin
        case (rd_sel)
            2'b10:   cmd_rdata = irr;
            2'b11:   cmd_rdata = isr;
            default: cmd_rdata = '0;
        endcase
    end

    AST_ACK_MARKS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && !cmd_wr) |=> isr[$past(ack_idx)]); // R9

    AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && !level_mask[ack_idx] && !raise_vec[ack_idx]) |=> !irr[$past(ack_idx)]); // R9

endmodule

// File: rtl/pic_pair_arbiter.sv
// Picks the request offered to the CPU across both controllers.
// Master bits below CASC_BIT rank first, then the slave, then the rest of
// the master. Assumes pending vectors are already masked.
module pic_pair_arbiter
    import pic_pair_pkg::*;
#(
    parameter int CASC_BIT = 2
) (
    input  logic [UNIT_W-1:0] m_pend,
    input  logic [UNIT_W-1:0] s_pend,
    input  logic [UNIT_W-1:0] m_base,
    input  logic [UNIT_W-1:0] s_base,
    output logic              win_any,
    output logic              win_slave,
    output logic [IDX_W-1:0]  m_idx,
    output logic [IDX_W-1:0]  s_idx,
    output logic [UNIT_W-1:0] vector
);

    localparam logic [UNIT_W-1:0] LOW_MASK = (UNIT_W'(1) << CASC_BIT) - UNIT_W'(1);

    logic [UNIT_W-1:0] m_low;

    // Priority resolution and vector formation.
    always_comb begin
        m_low     = m_pend & LOW_MASK;
        win_any   = 1'b0;
        win_slave = 1'b0;
        m_idx     = '0;
        s_idx     = lowest_idx(s_pend);
        vector    = '0;
        if (|m_low) begin
            win_any = 1'b1;
            m_idx   = lowest_idx(m_low);
            vector  = m_base + UNIT_W'(m_idx);
        end else if (|s_pend) begin
            win_any   = 1'b1;
            win_slave = 1'b1;
            m_idx     = IDX_W'(CASC_BIT);
            vector    = s_base + UNIT_W'(s_idx);
        end else if (|m_pend) begin
            win_any = 1'b1;
            m_idx   = lowest_idx(m_pend);
            vector  = m_base + UNIT_W'(m_idx);
        end
    end

endmodule

// File: rtl/pic_pair_top.sv
// Master/slave interrupt controller pair behind a byte I/O bus.
// Decodes six addresses, routes numbered raise/lower strobes to the two
// controllers, folds slave requests into the master cascade bit, holds the
// edge/level registers and drives one registered CPU interrupt and a vector.
// Assumes a read returns data combinationally for the address presented.
module pic_pair_top
    import pic_pair_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter int                LINE_W      = 5,
    parameter int                CASC_BIT    = 2,
    parameter logic [ADDR_W-1:0] M_CMD_ADDR  = 16'h0020,
    parameter logic [ADDR_W-1:0] M_DATA_ADDR = 16'h0021,
    parameter logic [ADDR_W-1:0] S_CMD_ADDR  = 16'h00A0,
    parameter logic [ADDR_W-1:0] S_DATA_ADDR = 16'h00A1,
    parameter logic [ADDR_W-1:0] M_LVL_ADDR  = 16'h04D0,
    parameter logic [ADDR_W-1:0] S_LVL_ADDR  = 16'h04D1,
    parameter logic [UNIT_W-1:0] M_LVL_MASK  = 8'hF8,
    parameter logic [UNIT_W-1:0] S_LVL_MASK  = 8'hDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [UNIT_W-1:0] bus_wdata,
    output logic [UNIT_W-1:0] bus_rdata,
    input  logic              req_raise,
    input  logic              req_lower,
    input  logic [LINE_W-1:0] req_line,
    input  logic              intr_ack,
    output logic              cpu_intr,
    output logic [UNIT_W-1:0] intr_vector
);

    localparam int N_LINES = 2 * UNIT_W;

    logic [N_LINES-1:0] raise_all;
    logic [N_LINES-1:0] lower_all;
    logic [UNIT_W-1:0]  m_raise, s_raise, m_lower, s_lower;

    logic m_cmd_wr, m_data_wr, s_cmd_wr, s_data_wr, m_lvl_wr, s_lvl_wr, ctrl_wr;

    logic [UNIT_W-1:0] m_irr, m_isr, m_imr, m_base, m_cmd_rd, m_lvl;
    logic [UNIT_W-1:0] s_irr, s_isr, s_imr, s_base, s_cmd_rd, s_lvl;
    logic [UNIT_W-1:0] m_pend, s_pend;

    logic              win_any, win_slave;
    logic [IDX_W-1:0]  m_idx, s_idx;
    logic              pend_any;

    // Per-line decode of the numbered raise and lower strobes.
    generate
        for (genvar g = 0; g < N_LINES; g++) begin : g_line
            assign raise_all[g] = req_raise && (req_line == LINE_W'(g));
            assign lower_all[g] = req_lower && !req_raise && (req_line == LINE_W'(g));
        end
    endgenerate

    // Split lines between controllers and fold the slave into the cascade bit.
    always_comb begin
        s_raise = raise_all[N_LINES-1:UNIT_W];
        s_lower = lower_all[N_LINES-1:UNIT_W];
        m_raise = raise_all[UNIT_W-1:0] | ((|s_raise) ? (UNIT_W'(1) << CASC_BIT) : '0);
        m_lower = lower_all[UNIT_W-1:0];
    end

    // Address decode of bus writes.
    always_comb begin
        m_cmd_wr  = bus_wr && (bus_addr == M_CMD_ADDR);
        m_data_wr = bus_wr && (bus_addr == M_DATA_ADDR);
        s_cmd_wr  = bus_wr && (bus_addr == S_CMD_ADDR);
        s_data_wr = bus_wr && (bus_addr == S_DATA_ADDR);
        m_lvl_wr  = bus_wr && (bus_addr == M_LVL_ADDR);
        s_lvl_wr  = bus_wr && (bus_addr == S_LVL_ADDR);
        ctrl_wr   = m_cmd_wr || m_data_wr || s_cmd_wr || s_data_wr;
    end

    pic_level_reg #(.WMASK(M_LVL_MASK)) u_m_lvl (
        .clk(clk), .rst_n(rst_n), .wr(m_lvl_wr), .wdata(bus_wdata), .q(m_lvl)
    );

    pic_level_reg #(.WMASK(S_LVL_MASK)) u_s_lvl (
        .clk(clk), .rst_n(rst_n), .wr(s_lvl_wr), .wdata(bus_wdata), .q(s_lvl)
    );

    pic_unit u_master (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(m_cmd_wr), .data_wr(m_data_wr), .wdata(bus_wdata),
        .raise_vec(m_raise), .lower_vec(m_lower),
        .ack_vld(intr_ack && win_any), .ack_idx(m_idx), .level_mask(m_lvl),
        .irr(m_irr), .isr(m_isr), .imr(m_imr), .vec_base(m_base), .cmd_rdata(m_cmd_rd)
    );

    pic_unit u_slave (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(s_cmd_wr), .data_wr(s_data_wr), .wdata(bus_wdata),
        .raise_vec(s_raise), .lower_vec(s_lower),
        .ack_vld(intr_ack && win_slave), .ack_idx(s_idx), .level_mask(s_lvl),
        .irr(s_irr), .isr(s_isr), .imr(s_imr), .vec_base(s_base), .cmd_rdata(s_cmd_rd)
    );

    // Unmasked pending requests of both controllers.
    always_comb begin
        m_pend   = m_irr & ~m_imr;
        s_pend   = s_irr & ~s_imr;
        pend_any = (|m_pend) || (|s_pend);
    end

    pic_pair_arbiter #(.CASC_BIT(CASC_BIT)) u_arb (
        .m_pend(m_pend), .s_pend(s_pend), .m_base(m_base), .s_base(s_base),
        .win_any(win_any), .win_slave(win_slave), .m_idx(m_idx), .s_idx(s_idx),
        .vector(intr_vector)
    );

    // CPU interrupt register, withdrawn after any controller write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_intr <= 1'b0;
        end else begin
            cpu_intr <= ctrl_wr ? 1'b0 : pend_any;
        end
    end

    // Read data selection by address.
    always_comb begin
        case (bus_addr)
            M_CMD_ADDR:  bus_rdata = m_cmd_rd;
            M_DATA_ADDR: bus_rdata = m_imr;
            S_CMD_ADDR:  bus_rdata = s_cmd_rd;
            S_DATA_ADDR: bus_rdata = s_imr;
            M_LVL_ADDR:  bus_rdata = m_lvl;
            S_LVL_ADDR:  bus_rdata = s_lvl;
            default:     bus_rdata = '1;
        endcase
    end

    AST_WRITE_WITHDRAWS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !cpu_intr); // R7

    AST_PENDING_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_any && !ctrl_wr) |=> cpu_intr); // R7

    AST_CASCADE_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_raise && (req_line >= LINE_W'(UNIT_W)) && (req_line < LINE_W'(N_LINES)))
            |=> (m_irr[CASC_BIT] && (|s_irr))); // R3

endmodule

// File: tb/tb_pic_pair_top.sv
`timescale 1ns/1ps
module tb_pic_pair_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h0;
    logic [7:0]  bus_rdata;
    logic        req_raise = 1'b0;
    logic        req_lower = 1'b0;
    logic [4:0]  req_line = 5'd0;
    logic        intr_ack = 1'b0;
    logic        cpu_intr;
    logic [7:0]  intr_vector;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pic_pair_top dut (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_raise(req_raise), .req_lower(req_lower), .req_line(req_line),
        .intr_ack(intr_ack), .cpu_intr(cpu_intr), .intr_vector(intr_vector)
    );

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic line_op(input int n, input bit up);
        @(negedge clk);
        req_line = 5'(n); req_raise = up; req_lower = !up;
        @(negedge clk);
        req_raise = 1'b0; req_lower = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        intr_ack = 1'b1;
        @(negedge clk);
        intr_ack = 1'b0;
    endtask

    function automatic logic [7:0] exp_vec(input int n);
        return (n < 8) ? 8'(8'h20 + n) : 8'(8'h28 + n - 8);
    endfunction

    function automatic int rank(input int n);
        return (n < 2) ? n : (n >= 8) ? n - 6 : n + 8;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d, m, s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check8({7'd0, cpu_intr}, 8'h00, "R1 cpu_intr");
        check8(intr_vector, 8'h00, "R1 vector");
        rd(16'h0021, d); check8(d, 8'h00, "R1 master mask");
        rd(16'h00A1, d); check8(d, 8'h00, "R1 slave mask");
        rd(16'h04D0, d); check8(d, 8'h00, "R1 master level");
        rd(16'h04D1, d); check8(d, 8'h00, "R1 slave level");
        rd(16'h0020, d); check8(d, 8'h00, "R1 master request");

        // R2 unmapped reads
        rd(16'h0022, d); check8(d, 8'hFF, "R2 unmapped read 0x022");
        rd(16'h04D2, d); check8(d, 8'hFF, "R2 unmapped read 0x4D2");

        // R4 sweep of edge/level registers over all byte values
        for (int v = 0; v < 256; v++) begin
            wr(16'h04D0, 8'(v));
            wr(16'h04D1, 8'(~v));
            rd(16'h04D0, d); check8(d, 8'(v) & 8'hF8, "R4 master level mask");
            rd(16'h04D1, d); check8(d, 8'(~v) & 8'hDE, "R4 slave level mask");
        end
        wr(16'h04D0, 8'h18);
        wr(16'h04D2, 8'hFF);  // R2 unmapped write must leave registers alone
        wr(16'h0022, 8'hFF);
        rd(16'h04D0, d); check8(d, 8'h18, "R2 unmapped write ignored");
        rd(16'h0021, d); check8(d, 8'h00, "R2 unmapped write mask untouched");
        wr(16'h04D0, 8'h00);
        wr(16'h04D1, 8'h00);

        // R5 master: full path with cascade and mode bytes
        wr(16'h0020, 8'h11);
        wr(16'h0021, 8'h20);
        rd(16'h0021, d); check8(d, 8'h00, "R5 base byte not a mask");
        wr(16'h0021, 8'h04);
        rd(16'h0021, d); check8(d, 8'h00, "R5 cascade byte not a mask");
        wr(16'h0021, 8'h01);
        rd(16'h0021, d); check8(d, 8'h00, "R5 mode byte not a mask");
        wr(16'h0021, 8'h5A);
        rd(16'h0021, d); check8(d, 8'h5A, "R5 master mask after init");
        wr(16'h0021, 8'h00);
        // R5 slave: short path, single mode and no mode byte
        wr(16'h00A0, 8'h12);
        wr(16'h00A1, 8'h28);
        wr(16'h00A1, 8'h33);
        rd(16'h00A1, d); check8(d, 8'h33, "R5 slave mask after short init");
        wr(16'h00A1, 8'h00);

        // R3 R7 R8 sweep of every line number, in range or not
        for (int n = 0; n < 32; n++) begin
            line_op(n, 1'b1);
            @(negedge clk);
            m = (n < 8) ? 8'(1 << n) : (n < 16) ? 8'h04 : 8'h00;
            s = (n >= 8 && n < 16) ? 8'(1 << (n - 8)) : 8'h00;
            rd(16'h0020, d); check8(d, m, "R3 master request bits");
            rd(16'h00A0, d); check8(d, s, "R3 slave request bits");
            check8({7'd0, cpu_intr}, {7'd0, (n < 16)}, "R7 cpu_intr after raise");
            check8(intr_vector, (n < 16) ? exp_vec(n) : 8'h00, "R8 single line vector");
            line_op(n, 1'b0);
            if (n >= 8 && n < 16) begin
                rd(16'h0020, d); check8(d, 8'h04, "R3 slave lower keeps cascade bit");
                line_op(2, 1'b0);
            end
            rd(16'h0020, d); check8(d, 8'h00, "R3 master cleared by lower");
            rd(16'h00A0, d); check8(d, 8'h00, "R3 slave cleared by lower");
        end

        // R8 pairwise priority across all sixteen lines
        for (int a = 0; a < 16; a++) begin
            for (int b = a + 1; b < 16; b++) begin
                line_op(a, 1'b1);
                line_op(b, 1'b1);
                check8(intr_vector, exp_vec(rank(a) < rank(b) ? a : b), "R8 pair priority");
                line_op(a, 1'b0);
                line_op(b, 1'b0);
                line_op(2, 1'b0);
            end
        end

        // R8 masked request is skipped
        wr(16'h0021, 8'h10);
        line_op(4, 1'b1);
        @(negedge clk);
        check8({7'd0, cpu_intr}, 8'h00, "R8 masked line no cpu_intr");
        check8(intr_vector, 8'h00, "R8 masked line no vector");
        line_op(9, 1'b1);
        check8(intr_vector, 8'h29, "R8 slave wins over masked master");
        line_op(9, 1'b0);
        line_op(2, 1'b0);
        wr(16'h0021, 8'h00);

        // R7 withdrawal on a controller write, not on other writes
        @(negedge clk);
        check8({7'd0, cpu_intr}, 8'h01, "R7 pending line 4");
        wr(16'h0021, 8'h00);
        check8({7'd0, cpu_intr}, 8'h00, "R7 withdrawn after data write");
        @(negedge clk);
        check8({7'd0, cpu_intr}, 8'h01, "R7 restored next cycle");
        wr(16'h04D1, 8'h00);
        check8({7'd0, cpu_intr}, 8'h01, "R7 level register write keeps output");
        wr(16'h0099, 8'h00);
        check8({7'd0, cpu_intr}, 8'h01, "R2 unmapped write keeps output");
        line_op(4, 1'b0);

        // R6 read select
        wr(16'h0020, 8'h08);
        rd(16'h0020, d); check8(d, 8'h00, "R6 select 00 reads zero");

        // R9 edge acknowledge on master and slave
        line_op(3, 1'b1);
        ack();
        wr(16'h0020, 8'h0A);
        rd(16'h0020, d); check8(d, 8'h00, "R9 edge request cleared");
        wr(16'h0020, 8'h0B);
        rd(16'h0020, d); check8(d, 8'h08, "R6 R9 in-service after ack");
        line_op(10, 1'b1);
        check8(intr_vector, 8'h2A, "R8 slave vector");
        ack();
        rd(16'h0020, d); check8(d, 8'h0C, "R9 master in-service gets cascade bit");
        wr(16'h00A0, 8'h0B);
        rd(16'h00A0, d); check8(d, 8'h04, "R9 slave in-service");
        wr(16'h00A0, 8'h0A);
        rd(16'h00A0, d); check8(d, 8'h00, "R9 slave edge request cleared");
        wr(16'h0020, 8'h0A);
        rd(16'h0020, d); check8(d, 8'h00, "R9 master cascade request cleared");

        // R10 end-of-interrupt commands
        wr(16'h0020, 8'h20);
        wr(16'h0020, 8'h0B);
        rd(16'h0020, d); check8(d, 8'h08, "R10 non-specific clears lowest");
        wr(16'h0020, 8'h63);
        rd(16'h0020, d); check8(d, 8'h00, "R10 specific clears level 3");
        wr(16'h00A0, 8'h20);
        wr(16'h00A0, 8'h0B);
        rd(16'h00A0, d); check8(d, 8'h00, "R10 slave non-specific");

        // R9 level-triggered acknowledge keeps the request
        wr(16'h04D0, 8'h08);
        line_op(3, 1'b1);
        ack();
        rd(16'h0020, d); check8(d, 8'h08, "R9 level in-service");
        wr(16'h0020, 8'h0A);
        rd(16'h0020, d); check8(d, 8'h08, "R9 level request kept");
        wr(16'h0020, 8'hC3);
        wr(16'h0020, 8'h0B);
        rd(16'h0020, d); check8(d, 8'h08, "R10 other command no effect");
        line_op(3, 1'b0);
        wr(16'h0020, 8'h20);
        rd(16'h0020, d); check8(d, 8'h00, "R10 final release");
        wr(16'h04D0, 8'h00);
        @(negedge clk);
        check8({7'd0, cpu_intr}, 8'h00, "R7 idle at end");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule